// File: doc/BRIEF.md
# Microprogram Sequencer with Compact Jump Types

This block is the control unit of a multi-cycle single-bus processor datapath. It keeps a 6-bit micro-program counter and a combinational control store. Each control-store word carries the datapath control vector for that step, a 3-bit jump-type code and a 6-bit absolute target. Next-state logic picks the following micro-address from one of these sources: the incremented micro-PC, the current micro-PC held, the absolute target, or an entry address that a small decoder derives from the instruction opcode.

The stored microprogram implements a shared fetch routine and routines for register ALU operations, immediate ALU operations, word load, word store, branch-if-equal, plain jump, register jump and jump-and-link. Memory waits are handled by steps that hold in place while `busy` is high. Branches test `zero`. An opcode outside the known groups sends the sequencer to a halt step, which it never leaves, and raises a sticky `illegal` flag.

Top module: `useq_top`

## Requirements
- R1: A step of jump type step-on moves to micro-PC+1 on the next clock, whatever `busy` and `zero` are.
- R2: A wait step holds the micro-PC while `busy` is high and moves to micro-PC+1 in the first cycle that `busy` is low. No other step looks at `busy`. The wait steps are address 1 (instruction read), 12 (load data) and 17 (store data).
- R3: Every instruction routine ends in a step of jump type goto, which returns to address 0.
- R4: Address 2 dispatches on `opcode` to these entry addresses: 0110011→3 (register ALU), 0010011→6 (immediate ALU), 0000011→9 (load), 0100011→14 (store), 1100011→19 (branch-if-equal), 1101011→25 (jump), 1100111→28 (register jump), 1101111→30 (jump-and-link).
- R5: Branch step 21 goes to address 0 when `zero` is low and to 22 when it is high. The taken path is 22, 23, 24, then 0. No other step looks at `zero`.
- R6: While `rst_n` is sampled low, the micro-PC becomes 0 and `illegal` becomes 0.
- R7: Any other opcode at address 2 moves the micro-PC to 35 and sets `illegal` in the same cycle. Both stay until reset.
- R8: Fetch runs through addresses 0, 1 and 2. The routine lengths are: register ALU 3..5, immediate ALU 6..8, load 9..13, store 14..18, jump 25..27, register jump 28..29, jump-and-link 30..34.
- R9: `ctrl` bit 1 (memory write) is high only at address 17. `ctrl` bit 10 (register write) is high only at addresses 5, 8, 12 and 31.
- R10: `ctrl` bit 14 (PC load) is high only at addresses 2, 24, 27, 29 and 34.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 7 | Opcode field of the instruction register |
| zero | input | 1 | Datapath equality/zero flag |
| busy | input | 1 | Memory access still in progress |
| ctrl | output | 19 | Datapath control vector of the current step |
| upc | output | 6 | Current micro-PC |
| illegal | output | 1 | Sticky flag: an undefined opcode was dispatched |

## Verification
Two kinds of overlap are provoked. In the first, `busy` is high while a non-wait step runs, including the dispatch step at address 2. In the second, `zero` is high during steps that never test it. In both cases the bench holds the condition on purpose in "noisy" instruction runs, so a sequencer that listened to the wrong condition would show up. Every cycle of the micro-PC trace is judged against a trace the bench builds from the routine tables, together with the register-write, memory-write and PC-load bits. Wait steps are also run with stalls of zero to five cycles, so that the release of `busy` and the step-on to the next address fall in one cycle.

// File: rtl/useq_pkg.sv
// Shared definitions for the microprogram sequencer: widths, jump types,
// the control-vector layout, routine entry addresses and opcode groups.
package useq_pkg;
    localparam int UPC_W = 6;
    localparam int OPC_W = 7;

    typedef logic [UPC_W-1:0] upc_t;

    typedef enum logic [2:0] {
        JT_NEXT   = 3'd0,
        JT_SPIN   = 3'd1,
        JT_ABS    = 3'd2,
        JT_DISP   = 3'd3,
        JT_FTRUE  = 3'd4,
        JT_FFALSE = 3'd5
    } jump_t;

    // Bus source selects for the register-file read port
    localparam logic [2:0] SEL_PC  = 3'd0;
    localparam logic [2:0] SEL_RS1 = 3'd1;
    localparam logic [2:0] SEL_RS2 = 3'd2;
    localparam logic [2:0] SEL_RD  = 3'd3;
    localparam logic [2:0] SEL_RA  = 3'd4;

    // Immediate formats
    localparam logic [1:0] IMM_I = 2'd0;
    localparam logic [1:0] IMM_S = 2'd1;
    localparam logic [1:0] IMM_B = 2'd2;
    localparam logic [1:0] IMM_J = 2'd3;

    // ALU operations
    localparam logic [2:0] AOP_ADD   = 3'd0;
    localparam logic [2:0] AOP_INC4  = 3'd1;
    localparam logic [2:0] AOP_DEC4  = 3'd2;
    localparam logic [2:0] AOP_FUNC  = 3'd3;
    localparam logic [2:0] AOP_JTARG = 3'd4;
    localparam logic [2:0] AOP_PASSA = 3'd5;
    localparam logic [2:0] AOP_SUB   = 3'd6;

    // Control vector, MSB first; en_mem is bit 0
    typedef struct packed {
        logic       ld_ir;
        logic       ld_a;
        logic       ld_b;
        logic       ld_ma;
        logic       ld_pc;
        logic [2:0] reg_sel;
        logic       reg_wr;
        logic       en_reg;
        logic [1:0] imm_sel;
        logic       en_imm;
        logic [2:0] alu_op;
        logic       en_alu;
        logic       mem_wr;
        logic       en_mem;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Routine entry addresses
    localparam int A_FETCH = 0;
    localparam int A_ALU   = 3;
    localparam int A_ALUI  = 6;
    localparam int A_LW    = 9;
    localparam int A_SW    = 14;
    localparam int A_BEQ   = 19;
    localparam int A_J     = 25;
    localparam int A_JR    = 28;
    localparam int A_JAL   = 30;
    localparam int A_HALT  = 35;

    // Opcode groups
    localparam logic [OPC_W-1:0] OP_ALU  = 7'b0110011;
    localparam logic [OPC_W-1:0] OP_ALUI = 7'b0010011;
    localparam logic [OPC_W-1:0] OP_LW   = 7'b0000011;
    localparam logic [OPC_W-1:0] OP_SW   = 7'b0100011;
    localparam logic [OPC_W-1:0] OP_BEQ  = 7'b1100011;
    localparam logic [OPC_W-1:0] OP_J    = 7'b1101011;
    localparam logic [OPC_W-1:0] OP_JR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OP_JAL  = 7'b1101111;
endpackage

// File: rtl/useq_rom.sv
// Combinational control store. For each micro-address it gives the control
// vector, the jump type and an absolute target. Unused addresses behave as
// the halt step. Assumes one bus source per step.
module useq_rom
    import useq_pkg::*;
(
    input  upc_t  upc,
    output ctrl_t ctrl,
    output jump_t jt,
    output upc_t  target
);
    // Microprogram contents, one case item per step
    always_comb begin
        ctrl   = '0;
        jt     = JT_NEXT;
        target = upc_t'(A_FETCH);
        case (int'(upc))
            // fetch: MA,A <- PC ; IR <- Mem ; PC <- A+4
            A_FETCH:     begin ctrl.reg_sel = SEL_PC; ctrl.en_reg = 1'b1; ctrl.ld_ma = 1'b1; ctrl.ld_a = 1'b1; end
            A_FETCH + 1: begin ctrl.en_mem = 1'b1; ctrl.ld_ir = 1'b1; jt = JT_SPIN; end
            A_FETCH + 2: begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_INC4; ctrl.ld_pc = 1'b1; jt = JT_DISP; end
            // register ALU
            A_ALU:       begin ctrl.reg_sel = SEL_RS1; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; end
            A_ALU + 1:   begin ctrl.reg_sel = SEL_RS2; ctrl.en_reg = 1'b1; ctrl.ld_b = 1'b1; end
            A_ALU + 2:   begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_FUNC; ctrl.reg_sel = SEL_RD; ctrl.reg_wr = 1'b1; jt = JT_ABS; end
            // immediate ALU
            A_ALUI:      begin ctrl.reg_sel = SEL_RS1; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; end
            A_ALUI + 1:  begin ctrl.en_imm = 1'b1; ctrl.imm_sel = IMM_I; ctrl.ld_b = 1'b1; end
            A_ALUI + 2:  begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_FUNC; ctrl.reg_sel = SEL_RD; ctrl.reg_wr = 1'b1; jt = JT_ABS; end
            // load word
            A_LW:        begin ctrl.reg_sel = SEL_RS1; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; end
            A_LW + 1:    begin ctrl.en_imm = 1'b1; ctrl.imm_sel = IMM_I; ctrl.ld_b = 1'b1; end
            A_LW + 2:    begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_ADD; ctrl.ld_ma = 1'b1; end
            A_LW + 3:    begin ctrl.en_mem = 1'b1; ctrl.reg_sel = SEL_RD; ctrl.reg_wr = 1'b1; jt = JT_SPIN; end
            A_LW + 4:    begin jt = JT_ABS; end
            // store word
            A_SW:        begin ctrl.reg_sel = SEL_RS1; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; end
            A_SW + 1:    begin ctrl.en_imm = 1'b1; ctrl.imm_sel = IMM_S; ctrl.ld_b = 1'b1; end
            A_SW + 2:    begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_ADD; ctrl.ld_ma = 1'b1; end
            A_SW + 3:    begin ctrl.reg_sel = SEL_RS2; ctrl.en_reg = 1'b1; ctrl.en_mem = 1'b1; ctrl.mem_wr = 1'b1; jt = JT_SPIN; end
            A_SW + 4:    begin jt = JT_ABS; end
            // branch if equal: compare, then PC <- (PC-4) + offset
            A_BEQ:       begin ctrl.reg_sel = SEL_RS1; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; end
            A_BEQ + 1:   begin ctrl.reg_sel = SEL_RS2; ctrl.en_reg = 1'b1; ctrl.ld_b = 1'b1; end
            A_BEQ + 2:   begin ctrl.alu_op = AOP_SUB; ctrl.reg_sel = SEL_PC; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; jt = JT_FFALSE; end
            A_BEQ + 3:   begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_DEC4; ctrl.ld_a = 1'b1; end
            A_BEQ + 4:   begin ctrl.en_imm = 1'b1; ctrl.imm_sel = IMM_B; ctrl.ld_b = 1'b1; end
            A_BEQ + 5:   begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_ADD; ctrl.ld_pc = 1'b1; jt = JT_ABS; end
            // plain jump
            A_J:         begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_DEC4; ctrl.ld_a = 1'b1; end
            A_J + 1:     begin ctrl.en_imm = 1'b1; ctrl.imm_sel = IMM_J; ctrl.ld_b = 1'b1; end
            A_J + 2:     begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_JTARG; ctrl.ld_pc = 1'b1; jt = JT_ABS; end
            // register jump
            A_JR:        begin ctrl.reg_sel = SEL_RS1; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; end
            A_JR + 1:    begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_PASSA; ctrl.ld_pc = 1'b1; jt = JT_ABS; end
            // jump and link: x1 <- PC, then PC <- target
            A_JAL:       begin ctrl.reg_sel = SEL_PC; ctrl.en_reg = 1'b1; ctrl.ld_a = 1'b1; end
            A_JAL + 1:   begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_PASSA; ctrl.reg_sel = SEL_RA; ctrl.reg_wr = 1'b1; end
            A_JAL + 2:   begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_DEC4; ctrl.ld_a = 1'b1; end
            A_JAL + 3:   begin ctrl.en_imm = 1'b1; ctrl.imm_sel = IMM_J; ctrl.ld_b = 1'b1; end
            A_JAL + 4:   begin ctrl.en_alu = 1'b1; ctrl.alu_op = AOP_JTARG; ctrl.ld_pc = 1'b1; jt = JT_ABS; end
            // halt and every unused address: loop on the halt step
            default:     begin jt = JT_ABS; target = upc_t'(A_HALT); end
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
// Opcode-group decoder. Maps the instruction opcode to the entry address of
// its routine; an unknown opcode yields the halt address with valid low.
module useq_dispatch
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output upc_t             entry,
    output logic             valid
);
    // Opcode-group lookup
    always_comb begin
        valid = 1'b1;
        case (opcode)
            OP_ALU:  entry = upc_t'(A_ALU);
            OP_ALUI: entry = upc_t'(A_ALUI);
            OP_LW:   entry = upc_t'(A_LW);
            OP_SW:   entry = upc_t'(A_SW);
            OP_BEQ:  entry = upc_t'(A_BEQ);
            OP_J:    entry = upc_t'(A_J);
            OP_JR:   entry = upc_t'(A_JR);
            OP_JAL:  entry = upc_t'(A_JAL);
            default: begin entry = upc_t'(A_HALT); valid = 1'b0; end
        endcase
    end
endmodule

// File: rtl/useq_nextpc.sv
// Next micro-address selector. Chooses between micro-PC+1, hold, absolute
// target and dispatch entry according to the jump type and the status inputs.
// Assumes busy and zero are stable before the clock edge.
module useq_nextpc
    import useq_pkg::*;
(
    input  upc_t  upc,
    input  jump_t jt,
    input  upc_t  target,
    input  upc_t  entry,
    input  logic  entry_ok,
    input  logic  zero,
    input  logic  busy,
    output upc_t  upc_nx
);
    upc_t upc_inc;

    // Incrementer shared by several jump types
    always_comb upc_inc = upc + upc_t'(1);

    // Source select
    always_comb begin
        case (jt)
            JT_NEXT:   upc_nx = upc_inc;
            JT_SPIN:   upc_nx = busy ? upc : upc_inc;
            JT_ABS:    upc_nx = target;
            JT_DISP:   upc_nx = entry_ok ? entry : upc_t'(A_HALT);
            JT_FTRUE:  upc_nx = zero ? target : upc_inc;
            JT_FFALSE: upc_nx = zero ? upc_inc : target;
            default:   upc_nx = upc_t'(A_HALT);
        endcase
    end
endmodule

// File: rtl/useq_top.sv
// Microprogram sequencer top. Holds the micro-PC and the sticky illegal
// flag, and drives the control vector of the current step out of the control
// store. Reset is synchronous and active low; the micro-PC resets to fetch.
module useq_top
    import useq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode,
    input  logic                 zero,
    input  logic                 busy,
    output logic [CTRL_W-1:0]    ctrl,
    output logic [UPC_W-1:0]     upc,
    output logic                 illegal
);
    upc_t  upc_q;
    upc_t  upc_nx;
    ctrl_t rom_ctrl;
    jump_t rom_jt;
    upc_t  rom_tgt;
    upc_t  disp_entry;
    logic  disp_ok;
    logic  illegal_q;

    useq_rom u_rom (
        .upc    (upc_q),
        .ctrl   (rom_ctrl),
        .jt     (rom_jt),
        .target (rom_tgt)
    );

    useq_dispatch u_disp (
        .opcode (opcode),
        .entry  (disp_entry),
        .valid  (disp_ok)
    );

    useq_nextpc u_next (
        .upc      (upc_q),
        .jt       (rom_jt),
        .target   (rom_tgt),
        .entry    (disp_entry),
        .entry_ok (disp_ok),
        .zero     (zero),
        .busy     (busy),
        .upc_nx   (upc_nx)
    );

    // Micro-PC register
    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= upc_t'(A_FETCH);
        else        upc_q <= upc_nx;
    end

    // Sticky illegal flag, raised together with entry into halt
    always_ff @(posedge clk) begin
        if (!rst_n)                            illegal_q <= 1'b0;
        else if (upc_nx == upc_t'(A_HALT))     illegal_q <= 1'b1;
    end

    assign ctrl    = rom_ctrl;
    assign upc     = upc_q;
    assign illegal = illegal_q;

    // Step-on type advances by one
    assert_next_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_jt == JT_NEXT) |=> (upc_q == upc_t'($past(upc_q) + upc_t'(1))));

    // Wait step holds while busy
    assert_spin_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_jt == JT_SPIN && busy) |=> $stable(upc_q));

    // Wait step releases when busy drops
    assert_spin_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_jt == JT_SPIN && !busy) |=> (upc_q == upc_t'($past(upc_q) + upc_t'(1))));

    // Goto lands on the stored target
    assert_goto_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_jt == JT_ABS) |=> (upc_q == $past(rom_tgt)));

    // Dispatch lands on the decoded entry
    assert_dispatch_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_jt == JT_DISP && disp_ok) |=> (upc_q == $past(disp_entry)));

    // Branch-on-false skips to target when zero is low
    assert_ffalse_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_jt == JT_FFALSE && !zero) |=> (upc_q == $past(rom_tgt)));

    // Halt is never left and the flag never clears without reset
    assert_halt_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == upc_t'(A_HALT)) |=> (upc_q == upc_t'(A_HALT)));

    assert_illegal_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |=> illegal_q);
endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver walks each instruction's micro-steps, pushing
// the expected micro-PC, control bits and flag; a monitor pops and compares.
module sim_useq_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  opcode;
    logic        zero;
    logic        busy;
    logic [18:0] ctrl;
    logic [5:0]  upc;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit ill_exp = 1'b0;

    typedef struct packed {
        logic [5:0] a;
        logic       mw;
        logic       rw;
        logic       lp;
        logic       ill;
    } item_t;

    item_t q_exp[$];
    string q_tag[$];

    localparam logic [6:0] O_ALU  = 7'b0110011;
    localparam logic [6:0] O_ALUI = 7'b0010011;
    localparam logic [6:0] O_LW   = 7'b0000011;
    localparam logic [6:0] O_SW   = 7'b0100011;
    localparam logic [6:0] O_BEQ  = 7'b1100011;
    localparam logic [6:0] O_J    = 7'b1101011;
    localparam logic [6:0] O_JR   = 7'b1100111;
    localparam logic [6:0] O_JAL  = 7'b1101111;
    localparam logic [6:0] O_BAD  = 7'b1111111;

    always #2.5 clk = ~clk;

    useq_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .zero    (zero),
        .busy    (busy),
        .ctrl    (ctrl),
        .upc     (upc),
        .illegal (illegal)
    );

    // Driver: push the expectation for the current cycle, set busy, advance
    task automatic step(input logic [5:0] a, input logic b, input string tag);
        item_t it;
        it.a   = a;
        it.mw  = (a == 6'd17);
        it.rw  = (a == 6'd5 || a == 6'd8 || a == 6'd12 || a == 6'd31);
        it.lp  = (a == 6'd2 || a == 6'd24 || a == 6'd27 || a == 6'd29 || a == 6'd34);
        it.ill = ill_exp;
        q_exp.push_back(it);
        q_tag.push_back(tag);
        busy = b;
        @(negedge clk);
    endtask

    task automatic wait_step(input logic [5:0] a, input int n);
        for (int i = 0; i <= n; i++) step(a, (i < n), "R2");
    endtask

    task automatic seq(input int first, input int last, input logic noise);
        for (int k = first; k <= last; k++) step(6'(k), noise, (k == first) ? "R4" : "R8");
    endtask

    // One instruction: fetch, then its routine
    task automatic instr(input logic [6:0] op, input int sf, input int sm,
                         input logic z, input logic noise);
        opcode = op;
        zero   = z;
        step(6'd0, noise, "R3");
        wait_step(6'd1, sf);
        step(6'd2, noise, "R8");
        case (op)
            O_ALU:  seq(3, 5, noise);
            O_ALUI: seq(6, 8, noise);
            O_LW:   begin seq(9, 11, noise);  wait_step(6'd12, sm); step(6'd13, noise, "R3"); end
            O_SW:   begin seq(14, 16, noise); wait_step(6'd17, sm); step(6'd18, noise, "R9"); end
            O_BEQ:  begin
                        seq(19, 20, noise);
                        step(6'd21, noise, "R5");
                        if (z) begin
                            step(6'd22, noise, "R5");
                            step(6'd23, noise, "R5");
                            step(6'd24, noise, "R5");
                        end
                    end
            O_J:    seq(25, 27, noise);
            O_JR:   seq(28, 29, noise);
            O_JAL:  seq(30, 34, noise);
            default: ;
        endcase
    endtask

    // Monitor: compare the design against the scoreboard each cycle
    initial begin
        item_t it;
        string tg;
        forever begin
            @(negedge clk);
            #1;
            if (q_exp.size() > 0) begin
                it = q_exp.pop_front();
                tg = q_tag.pop_front();
                checks++;
                if (upc !== it.a) begin
                    fails++;
                    $display("FAIL %s upc: actual %0d expected %0d", tg, upc, it.a);
                end
                checks++;
                if ({ctrl[1], ctrl[10]} !== {it.mw, it.rw}) begin
                    fails++;
                    $display("FAIL R9 at upc %0d mem_wr/reg_wr: actual %b%b expected %b%b",
                             it.a, ctrl[1], ctrl[10], it.mw, it.rw);
                end
                checks++;
                if (ctrl[14] !== it.lp) begin
                    fails++;
                    $display("FAIL R10 at upc %0d pc_load: actual %b expected %b", it.a, ctrl[14], it.lp);
                end
                checks++;
                if (illegal !== it.ill) begin
                    fails++;
                    $display("FAIL R7 at upc %0d illegal: actual %b expected %b", it.a, illegal, it.ill);
                end
            end
        end
    end

    task automatic check_reset;
        #1;
        checks++;
        if (upc !== 6'd0 || illegal !== 1'b0) begin
            fails++;
            $display("FAIL R6 reset state: actual upc %0d illegal %b expected 0 0", upc, illegal);
        end
    endtask

    // Stimulus
    initial begin
        rst_n = 1'b0; opcode = '0; zero = 1'b0; busy = 1'b0;
        repeat (3) @(negedge clk);
        check_reset();                     // R6
        @(negedge clk);
        rst_n = 1'b1;
        instr(O_ALU,  0, 0, 1'b0, 1'b0);   // R4 R8
        instr(O_ALUI, 2, 0, 1'b1, 1'b1);   // R1 busy/zero ignored
        instr(O_LW,   1, 3, 1'b0, 1'b0);   // R2 data stall
        instr(O_SW,   0, 0, 1'b1, 1'b1);   // R9 no stall
        instr(O_SW,   4, 1, 1'b0, 1'b0);
        instr(O_LW,   0, 0, 1'b1, 1'b1);
        instr(O_BEQ,  0, 0, 1'b1, 1'b0);   // R5 taken
        instr(O_BEQ,  0, 0, 1'b0, 1'b1);   // R5 not taken
        instr(O_BEQ,  3, 0, 1'b1, 1'b1);
        instr(O_J,    1, 0, 1'b0, 1'b0);   // R10
        instr(O_JR,   0, 0, 1'b1, 1'b1);
        instr(O_JAL,  2, 0, 1'b0, 1'b0);
        instr(O_ALU,  5, 0, 1'b0, 1'b1);
        // undefined opcode: R7
        opcode = O_BAD; zero = 1'b0;
        step(6'd0, 1'b0, "R3");
        wait_step(6'd1, 1);
        step(6'd2, 1'b0, "R8");
        ill_exp = 1'b1;
        step(6'd35, 1'b0, "R7");
        step(6'd35, 1'b1, "R7");
        opcode = O_ALU; zero = 1'b1;
        for (int i = 0; i < 3; i++) step(6'd35, 1'b1, "R7");
        // reset clears halt and flag: R6
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset();
        @(negedge clk);
        rst_n = 1'b1;
        ill_exp = 1'b0;
        instr(O_JAL, 0, 0, 1'b1, 1'b1);
        instr(O_ALUI, 0, 0, 1'b0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule